// File: doc/BRIEF.md
# Boundary Scan Test Port

This block gives a small device a serial test port with one boundary cell on every I/O pin. A sixteen-state controller advances on the test clock and is steered by a single mode-select line. It routes the serial data input through one of five registers: the instruction register, a one-bit skip stage, a fixed identification word, a user word, or the boundary cell chain. The chosen register then drives the serial data output. Several devices can share one port when each device's serial output feeds the next device's serial input.

Each boundary cell has a capture/shift flop and a separate update flop. The loaded instruction sets what the cells do. With most instructions they are transparent. With the observe instruction they capture pin and core values while the device runs normally. With the pin-drive instruction they drive the output pins and capture the input pins. With the core-drive instruction they drive the core inputs and capture the core outputs. The serial output changes on the falling test-clock edge. Its enable is high only while a register is shifting.

Top module: `scanport_top`

## Requirements
- R1: A low level on `test_rst_n` puts the controller in its reset state at once and loads the identification opcode (4'h1). Every clock spent in the reset state also reloads that opcode, so the first data scan after reset returns the identification word.
- R2: Five consecutive rising clock edges with `mode_sel` high bring the controller to the reset state from any state, with the identification opcode reloaded.
- R3: An instruction scan shifts out the capture pattern first, LSB first. The pattern is binary 01 in the two low bits with zeros above.
- R4: `ser_out_en` is high only while the controller is in a shift state (instruction or data). It changes on the falling clock edge, together with `ser_out`.
- R5: The identification opcode (4'h1) selects a 32-bit register. A data scan shifts out `ID_VALUE` LSB first, and bit 0 of that value is 1.
- R6: The user opcode (4'h4) selects a 32-bit register. A data scan shifts out `USER_VALUE` LSB first.
- R7: The all-ones opcode (4'hF) and every opcode without a meaning here (for example 4'h9) select a one-bit skip stage that captures 0. A data scan of n bits returns 0 followed by the first n-1 input bits.
- R8: Under the identification, user and skip instructions the cells are transparent: `core_in` equals `pin_in` and `pin_out` equals `core_out`.
- R9: The observe opcode (4'h2) captures `pin_in` into cells 0..NUM_IN-1 and `core_out` into cells NUM_IN..NUM_IN+NUM_OUT-1, while both directions stay transparent. Cell 0 is nearest `ser_out`.
- R10: The pin-drive opcode (4'h0) drives `pin_out[j]` from the update flop of cell NUM_IN+j and captures `pin_in`. `core_in` keeps following `pin_in`.
- R11: The core-drive opcode (4'h3) drives `core_in[i]` from the update flop of cell i and captures `core_out`. `pin_out` keeps following `core_out`.
- R12: Update flops load only on the clock edge that leaves the data-update state, so a driven `pin_out` or `core_in` holds its value through capture and shift.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| test_clk | input | 1 | Test clock |
| test_rst_n | input | 1 | Asynchronous active-low test reset (optional, see HAS_RST_PIN) |
| mode_sel | input | 1 | Controller steering input, sampled on rising edge |
| ser_in | input | 1 | Serial data input |
| ser_out | output | 1 | Serial data output, changes on falling edge |
| ser_out_en | output | 1 | High while `ser_out` carries valid shift data |
| pin_in | input | NUM_IN | Values arriving at the device input pins |
| core_in | output | NUM_IN | Values delivered to the core inputs |
| core_out | input | NUM_OUT | Values produced by the core for the output pins |
| pin_out | output | NUM_OUT | Values driven onto the device output pins |

## Verification
The hardest cases to reach from the ports are the ones that depend on what a previous scan left in the update flops. An instruction switch must make the pins or core inputs take the preloaded cell values at once, and shifting must then leave them alone until the data-update state. The stimulus first loads a known pattern under the observe instruction and then switches to pin-drive, and later to core-drive. In each case it samples the driven side while the controller sits in the update state, before the leaving edge, and again one edge later. Recovery through five high `mode_sel` cycles is started from inside a data shift, and the asynchronous reset is applied between clock edges while a non-default instruction is loaded.

// File: rtl/scanport_pkg.sv
package scanport_pkg;

   typedef enum logic [3:0] {
      ST_RESET   = 4'hF,
      ST_IDLE    = 4'hC,
      ST_SEL_DR  = 4'h7,
      ST_CAP_DR  = 4'h6,
      ST_SH_DR   = 4'h2,
      ST_EX1_DR  = 4'h1,
      ST_PAU_DR  = 4'h3,
      ST_EX2_DR  = 4'h0,
      ST_UPD_DR  = 4'h5,
      ST_SEL_IR  = 4'h4,
      ST_CAP_IR  = 4'hE,
      ST_SH_IR   = 4'hA,
      ST_EX1_IR  = 4'h9,
      ST_PAU_IR  = 4'hB,
      ST_EX2_IR  = 4'h8,
      ST_UPD_IR  = 4'hD
   } fsm_state_t;

   typedef enum logic [1:0] {
      DRS_SKIP  = 2'd0,
      DRS_ID    = 2'd1,
      DRS_USER  = 2'd2,
      DRS_BOUND = 2'd3
   } dr_sel_t;

   typedef struct packed {
      dr_sel_t sel;
      logic    drive_pins;
      logic    drive_core;
      logic    is_id;
   } ins_dec_t;

   function automatic fsm_state_t fsm_next(input fsm_state_t s, input logic m);
      fsm_state_t n;
      case (s)
         ST_RESET:  n = m ? ST_RESET  : ST_IDLE;
         ST_IDLE:   n = m ? ST_SEL_DR : ST_IDLE;
         ST_SEL_DR: n = m ? ST_SEL_IR : ST_CAP_DR;
         ST_CAP_DR: n = m ? ST_EX1_DR : ST_SH_DR;
         ST_SH_DR:  n = m ? ST_EX1_DR : ST_SH_DR;
         ST_EX1_DR: n = m ? ST_UPD_DR : ST_PAU_DR;
         ST_PAU_DR: n = m ? ST_EX2_DR : ST_PAU_DR;
         ST_EX2_DR: n = m ? ST_UPD_DR : ST_SH_DR;
         ST_UPD_DR: n = m ? ST_SEL_DR : ST_IDLE;
         ST_SEL_IR: n = m ? ST_RESET  : ST_CAP_IR;
         ST_CAP_IR: n = m ? ST_EX1_IR : ST_SH_IR;
         ST_SH_IR:  n = m ? ST_EX1_IR : ST_SH_IR;
         ST_EX1_IR: n = m ? ST_UPD_IR : ST_PAU_IR;
         ST_PAU_IR: n = m ? ST_EX2_IR : ST_PAU_IR;
         ST_EX2_IR: n = m ? ST_UPD_IR : ST_SH_IR;
         ST_UPD_IR: n = m ? ST_SEL_DR : ST_IDLE;
         default:   n = ST_RESET;
      endcase
      return n;
   endfunction

endpackage

// File: rtl/scanport_fsm.sv
module scanport_fsm
   import scanport_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       mode_sel,
   output fsm_state_t st
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st <= ST_RESET;
      else        st <= fsm_next(st, mode_sel);
   end

endmodule

// File: rtl/scanport_ir.sv
module scanport_ir
   import scanport_pkg::*;
#(
   parameter int unsigned     IR_W          = 4,
   parameter logic [IR_W-1:0] OP_PIN_DRIVE  = '0,
   parameter logic [IR_W-1:0] OP_ID         = 1,
   parameter logic [IR_W-1:0] OP_OBSERVE    = 2,
   parameter logic [IR_W-1:0] OP_CORE_DRIVE = 3,
   parameter logic [IR_W-1:0] OP_USER       = 4
)(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       ser_in,
   input  fsm_state_t st,
   output logic       ir_lsb,
   output ins_dec_t   dec
);

   localparam logic [IR_W-1:0] CAP_PATTERN = {{(IR_W-2){1'b0}}, 2'b01};

   logic [IR_W-1:0] ir_sh;
   logic [IR_W-1:0] ir_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ir_sh <= CAP_PATTERN;
         ir_q  <= OP_ID;
      end else begin
         if (st == ST_CAP_IR)     ir_sh <= CAP_PATTERN;
         else if (st == ST_SH_IR) ir_sh <= {ser_in, ir_sh[IR_W-1:1]};
         if (st == ST_RESET)       ir_q <= OP_ID;
         else if (st == ST_UPD_IR) ir_q <= ir_sh;
      end
   end

   assign ir_lsb = ir_sh[0];

   always_comb begin
      dec            = '0;
      dec.sel        = DRS_SKIP;
      if (ir_q == OP_ID) begin
         dec.sel     = DRS_ID;
         dec.is_id   = 1'b1;
      end else if (ir_q == OP_USER) begin
         dec.sel     = DRS_USER;
      end else if (ir_q == OP_OBSERVE) begin
         dec.sel     = DRS_BOUND;
      end else if (ir_q == OP_PIN_DRIVE) begin
         dec.sel        = DRS_BOUND;
         dec.drive_pins = 1'b1;
      end else if (ir_q == OP_CORE_DRIVE) begin
         dec.sel        = DRS_BOUND;
         dec.drive_core = 1'b1;
      end
   end

endmodule

// File: rtl/scanport_capreg.sv
module scanport_capreg #(
   parameter int unsigned      W   = 32,
   parameter logic [W-1:0]     CAP = '0
)(
   input  logic clk,
   input  logic rst_n,
   input  logic ser_in,
   input  logic capture,
   input  logic shift,
   output logic lsb
);

   logic [W-1:0] q;

   generate
      if (W == 1) begin : g_single
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)       q <= CAP;
            else if (capture) q <= CAP;
            else if (shift)   q <= ser_in;
         end
      end else begin : g_multi
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)       q <= CAP;
            else if (capture) q <= CAP;
            else if (shift)   q <= {ser_in, q[W-1:1]};
         end
      end
   endgenerate

   assign lsb = q[0];

endmodule

// File: rtl/scanport_bound.sv
module scanport_bound #(
   parameter int unsigned NUM_IN  = 4,
   parameter int unsigned NUM_OUT = 4
)(
   input  logic               clk,
   input  logic               rst_n,
   input  logic               ser_in,
   input  logic               capture,
   input  logic               shift,
   input  logic               update,
   input  logic               drive_pins,
   input  logic               drive_core,
   input  logic [NUM_IN-1:0]  pin_in,
   input  logic [NUM_OUT-1:0] core_out,
   output logic [NUM_IN-1:0]  core_in,
   output logic [NUM_OUT-1:0] pin_out,
   output logic               lsb
);

   localparam int unsigned TOT = NUM_IN + NUM_OUT;

   logic [TOT-1:0] sh;
   logic [TOT-1:0] upd;
   logic [TOT-1:0] cap_val;
   logic [TOT-1:0] chain_in;

   genvar k;
   generate
      for (k = 0; k < TOT; k++) begin : g_cell
         if (k < NUM_IN) begin : g_in_side
            assign cap_val[k] = pin_in[k];
         end else begin : g_out_side
            assign cap_val[k] = core_out[k-NUM_IN];
         end
         if (k == TOT-1) begin : g_head
            assign chain_in[k] = ser_in;
         end else begin : g_link
            assign chain_in[k] = sh[k+1];
         end
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               sh[k]  <= 1'b0;
               upd[k] <= 1'b0;
            end else begin
               if (capture)    sh[k] <= cap_val[k];
               else if (shift) sh[k] <= chain_in[k];
               if (update)     upd[k] <= sh[k];
            end
         end
      end

      for (k = 0; k < NUM_IN; k++) begin : g_core_mux
         assign core_in[k] = drive_core ? upd[k] : pin_in[k];
      end
      for (k = 0; k < NUM_OUT; k++) begin : g_pin_mux
         assign pin_out[k] = drive_pins ? upd[NUM_IN+k] : core_out[k];
      end
   endgenerate

   assign lsb = sh[0];

endmodule

// File: rtl/scanport_top.sv
module scanport_top
   import scanport_pkg::*;
#(
   parameter int unsigned     NUM_IN        = 4,
   parameter int unsigned     NUM_OUT       = 4,
   parameter int unsigned     IR_W          = 4,
   parameter int unsigned     ID_W          = 32,
   parameter logic [ID_W-1:0] ID_VALUE      = 32'h1A5C_3E01,
   parameter logic [ID_W-1:0] USER_VALUE    = 32'hC0DE_5A17,
   parameter bit              HAS_RST_PIN   = 1'b1,
   parameter logic [IR_W-1:0] OP_PIN_DRIVE  = '0,
   parameter logic [IR_W-1:0] OP_ID         = 1,
   parameter logic [IR_W-1:0] OP_OBSERVE    = 2,
   parameter logic [IR_W-1:0] OP_CORE_DRIVE = 3,
   parameter logic [IR_W-1:0] OP_USER       = 4
)(
   input  logic               test_clk,
   input  logic               test_rst_n,
   input  logic               mode_sel,
   input  logic               ser_in,
   output logic               ser_out,
   output logic               ser_out_en,
   input  logic [NUM_IN-1:0]  pin_in,
   output logic [NUM_IN-1:0]  core_in,
   input  logic [NUM_OUT-1:0] core_out,
   output logic [NUM_OUT-1:0] pin_out
);

   generate
      if (IR_W < 2) begin : g_bad_ir
         $error("scanport_top: IR_W must be at least 2");
      end
      if (ID_VALUE[0] != 1'b1) begin : g_bad_id
         $error("scanport_top: ID_VALUE bit 0 must be 1");
      end
      if (NUM_IN < 1 || NUM_OUT < 1) begin : g_bad_pins
         $error("scanport_top: need at least one input and one output pin");
      end
      if (OP_ID == OP_USER || OP_OBSERVE == OP_PIN_DRIVE ||
          OP_CORE_DRIVE == OP_PIN_DRIVE || OP_OBSERVE == OP_CORE_DRIVE) begin : g_bad_ops
         $error("scanport_top: opcodes must be distinct");
      end
      if (OP_PIN_DRIVE == '1 || OP_ID == '1 || OP_USER == '1 ||
          OP_OBSERVE == '1 || OP_CORE_DRIVE == '1) begin : g_bad_skip
         $error("scanport_top: all-ones opcode is reserved for the skip stage");
      end
   endgenerate

   logic       rst_int;
   fsm_state_t fsm_st;
   ins_dec_t   ins_dec;
   logic       ir_lsb, skip_lsb, id_lsb, user_lsb, bound_lsb;
   logic       cap_dr, sh_dr, upd_dr;
   logic       out_mux;

   generate
      if (HAS_RST_PIN) begin : g_rst_pin
         assign rst_int = test_rst_n;
      end else begin : g_rst_none
         assign rst_int = 1'b1;
      end
   endgenerate

   scanport_fsm u_fsm (
      .clk      (test_clk),
      .rst_n    (rst_int),
      .mode_sel (mode_sel),
      .st       (fsm_st)
   );

   scanport_ir #(
      .IR_W          (IR_W),
      .OP_PIN_DRIVE  (OP_PIN_DRIVE),
      .OP_ID         (OP_ID),
      .OP_OBSERVE    (OP_OBSERVE),
      .OP_CORE_DRIVE (OP_CORE_DRIVE),
      .OP_USER       (OP_USER)
   ) u_ir (
      .clk    (test_clk),
      .rst_n  (rst_int),
      .ser_in (ser_in),
      .st     (fsm_st),
      .ir_lsb (ir_lsb),
      .dec    (ins_dec)
   );

   assign cap_dr = (fsm_st == ST_CAP_DR);
   assign sh_dr  = (fsm_st == ST_SH_DR);
   assign upd_dr = (fsm_st == ST_UPD_DR);

   scanport_capreg #(.W(1), .CAP(1'b0)) u_skip (
      .clk     (test_clk),
      .rst_n   (rst_int),
      .ser_in  (ser_in),
      .capture (cap_dr && ins_dec.sel == DRS_SKIP),
      .shift   (sh_dr  && ins_dec.sel == DRS_SKIP),
      .lsb     (skip_lsb)
   );

   scanport_capreg #(.W(ID_W), .CAP(ID_VALUE)) u_id (
      .clk     (test_clk),
      .rst_n   (rst_int),
      .ser_in  (ser_in),
      .capture (cap_dr && ins_dec.sel == DRS_ID),
      .shift   (sh_dr  && ins_dec.sel == DRS_ID),
      .lsb     (id_lsb)
   );

   scanport_capreg #(.W(ID_W), .CAP(USER_VALUE)) u_user (
      .clk     (test_clk),
      .rst_n   (rst_int),
      .ser_in  (ser_in),
      .capture (cap_dr && ins_dec.sel == DRS_USER),
      .shift   (sh_dr  && ins_dec.sel == DRS_USER),
      .lsb     (user_lsb)
   );

   scanport_bound #(.NUM_IN(NUM_IN), .NUM_OUT(NUM_OUT)) u_bound (
      .clk        (test_clk),
      .rst_n      (rst_int),
      .ser_in     (ser_in),
      .capture    (cap_dr && ins_dec.sel == DRS_BOUND),
      .shift      (sh_dr  && ins_dec.sel == DRS_BOUND),
      .update     (upd_dr && ins_dec.sel == DRS_BOUND),
      .drive_pins (ins_dec.drive_pins),
      .drive_core (ins_dec.drive_core),
      .pin_in     (pin_in),
      .core_out   (core_out),
      .core_in    (core_in),
      .pin_out    (pin_out),
      .lsb        (bound_lsb)
   );

   always_comb begin
      if (fsm_st == ST_SH_IR) begin
         out_mux = ir_lsb;
      end else begin
         case (ins_dec.sel)
            DRS_ID:    out_mux = id_lsb;
            DRS_USER:  out_mux = user_lsb;
            DRS_BOUND: out_mux = bound_lsb;
            default:   out_mux = skip_lsb;
         endcase
      end
   end

   always_ff @(negedge test_clk or negedge rst_int) begin
      if (!rst_int) begin
         ser_out    <= 1'b0;
         ser_out_en <= 1'b0;
      end else begin
         ser_out    <= out_mux;
         ser_out_en <= (fsm_st == ST_SH_IR) || (fsm_st == ST_SH_DR);
      end
   end

endmodule

// File: rtl/scanport_chk.sv
module scanport_chk
   import scanport_pkg::*;
#(
   parameter int unsigned NUM_IN  = 4,
   parameter int unsigned NUM_OUT = 4
)(
   input logic               clk,
   input logic               rst_n,
   input logic               mode_sel,
   input fsm_state_t         st,
   input ins_dec_t           dec,
   input logic               ser_out_en,
   input logic [NUM_IN-1:0]  pin_in,
   input logic [NUM_IN-1:0]  core_in,
   input logic [NUM_OUT-1:0] core_out,
   input logic [NUM_OUT-1:0] pin_out
);

   logic [2:0] high_run;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              high_run <= '0;
      else if (!mode_sel)      high_run <= '0;
      else if (high_run != 3'd5) high_run <= high_run + 3'd1;
   end

   assert_reset_loads_id_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_RESET) |=> dec.is_id);

   assert_five_high_reset_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (high_run == 3'd5) |-> (st == ST_RESET));

   assert_enable_in_shift_R4: assert property (@(posedge clk) disable iff (!rst_n)
      ser_out_en == ((st == ST_SH_IR) || (st == ST_SH_DR)));

   assert_transparent_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (dec.sel != DRS_BOUND) |-> (core_in == pin_in && pin_out == core_out));

   assert_pins_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (dec.drive_pins && $past(dec.drive_pins) && $past(st) != ST_UPD_DR)
         |-> $stable(pin_out));

   assert_core_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (dec.drive_core && $past(dec.drive_core) && $past(st) != ST_UPD_DR)
         |-> $stable(core_in));

   assert_drive_exclusive_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !(dec.drive_pins && dec.drive_core));

endmodule

bind scanport_top scanport_chk #(.NUM_IN(NUM_IN), .NUM_OUT(NUM_OUT)) u_chk (
   .clk        (test_clk),
   .rst_n      (rst_int),
   .mode_sel   (mode_sel),
   .st         (fsm_st),
   .dec        (ins_dec),
   .ser_out_en (ser_out_en),
   .pin_in     (pin_in),
   .core_in    (core_in),
   .core_out   (core_out),
   .pin_out    (pin_out)
);

// File: tb/scanport_top_tb.sv
module scanport_top_tb;

   localparam int NI = 4;
   localparam int NO = 4;
   localparam logic [31:0] IDV  = 32'h1A5C_3E01;
   localparam logic [31:0] USRV = 32'hC0DE_5A17;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          mode_sel = 1'b1;
   logic          ser_in = 1'b0;
   logic          ser_out, ser_out_en;
   logic [NI-1:0] pin_in = '0;
   logic [NI-1:0] core_in;
   logic [NO-1:0] core_out = '0;
   logic [NO-1:0] pin_out;

   always #10 clk = ~clk;

   scanport_top u_dut (
      .test_clk   (clk),
      .test_rst_n (rst_n),
      .mode_sel   (mode_sel),
      .ser_in     (ser_in),
      .ser_out    (ser_out),
      .ser_out_en (ser_out_en),
      .pin_in     (pin_in),
      .core_in    (core_in),
      .core_out   (core_out),
      .pin_out    (pin_out)
   );

   typedef struct {
      string       tag;
      logic [63:0] val;
   } exp_t;

   exp_t        exp_q[$];
   logic [63:0] act_q[$];
   int          n_checks = 0;
   int          n_errors = 0;
   bit          done = 1'b0;
   logic [NO-1:0] pins_at_upd;
   logic [NI-1:0] core_at_upd;

   task automatic push_exp(input string tag, input logic [63:0] v);
      exp_q.push_back('{tag, v});
   endtask

   task automatic push_act(input logic [63:0] v);
      act_q.push_back(v);
   endtask

   initial begin : monitor
      logic [63:0] a;
      exp_t        e;
      forever begin
         wait (act_q.size() != 0);
         a = act_q.pop_front();
         n_checks++;
         if (exp_q.size() == 0) begin
            n_errors++;
            $display("FAIL scoreboard: actual %h expected none", a);
         end else begin
            e = exp_q.pop_front();
            if (a !== e.val) begin
               n_errors++;
               $display("FAIL %s: actual %h expected %h", e.tag, a, e.val);
            end
         end
      end
   end

   task automatic tick(input logic t, input logic d, output logic so);
      @(negedge clk);
      #2;
      so       = ser_out;
      mode_sel = t;
      ser_in   = d;
      @(posedge clk);
   endtask

   task automatic step(input logic t);
      logic dummy;
      tick(t, 1'b0, dummy);
   endtask

   // From idle: load an instruction, return the captured pattern
   task automatic scan_ir(input logic [3:0] op, output logic [3:0] cap);
      logic so;
      step(1); step(1); step(0); step(0);
      for (int i = 0; i < 4; i++) begin
         tick(i == 3, op[i], so);
         cap[i] = so;
      end
      step(1); step(0);
   endtask

   // From idle: n-bit data scan; records driven sides while in the update state
   task automatic scan_dr(input int n, input logic [63:0] din, output logic [63:0] dout);
      logic so;
      dout = '0;
      step(1); step(0); step(0);
      for (int i = 0; i < n; i++) begin
         tick(i == n-1, din[i], so);
         dout[i] = so;
      end
      step(1);
      #1;
      pins_at_upd = pin_out;
      core_at_upd = core_in;
      step(0);
      #1;
   endtask

   task automatic sample_now();
      @(negedge clk);
      #3;
   endtask

   initial begin : watchdog
      #(20 * 150000);
      if (!done) begin
         n_checks++;
         n_errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
         $finish;
      end
   end

   initial begin : stim
      logic [63:0] dout;
      logic [3:0]  cap;

      pin_in   = 4'hA;
      core_out = 4'h5;
      #25;
      rst_n = 1'b1;
      sample_now();
      push_exp("R4 enable low after reset", 64'd0);
      push_act({63'd0, ser_out_en});
      push_exp("R8 core_in transparent after reset", 64'hA);
      push_act({60'd0, core_in});
      push_exp("R8 pin_out transparent after reset", 64'h5);
      push_act({60'd0, pin_out});

      step(0);
      push_exp("R1 R5 id word after reset", {32'd0, IDV});
      scan_dr(32, 64'd0, dout);
      push_act(dout);

      push_exp("R3 ir capture pattern", 64'h1);
      scan_ir(4'h4, cap);
      push_act({60'd0, cap});
      push_exp("R6 user word", {32'd0, USRV});
      scan_dr(32, 64'd0, dout);
      push_act(dout);

      push_exp("R3 ir capture pattern again", 64'h1);
      scan_ir(4'hF, cap);
      push_act({60'd0, cap});
      push_exp("R7 skip stage one-bit delay", {56'd0, 8'b1011_0110, 1'b0} & 64'hFF);
      scan_dr(8, 64'hB6, dout);
      push_act(dout);
      sample_now();
      push_exp("R4 enable low in idle", 64'd0);
      push_act({63'd0, ser_out_en});

      scan_ir(4'h9, cap);
      push_exp("R7 undefined opcode acts as skip", {55'd0, 8'h5C, 1'b0} & 64'hFF);
      scan_dr(8, 64'h5C, dout);
      push_act(dout);
      push_exp("R8 transparent under skip", 64'h5A);
      push_act({56'd0, pin_out, core_in});

      pin_in   = 4'b1001;
      core_out = 4'b0110;
      scan_ir(4'h2, cap);
      push_exp("R9 observe captures pins and core", 64'h69);
      scan_dr(8, 64'hC3, dout);
      push_act(dout);
      push_exp("R9 observe keeps both sides transparent", 64'h69);
      push_act({56'd0, pin_out, core_in});

      pin_in = 4'b0011;
      scan_ir(4'h0, cap);
      #1;
      push_exp("R10 pins take preloaded cells", 64'hC);
      push_act({60'd0, pin_out});
      push_exp("R10 pin-drive captures pin_in", 64'h63);
      scan_dr(8, 64'h5A, dout);
      push_act(dout);
      push_exp("R12 pins hold until update edge", 64'hC);
      push_act({60'd0, pins_at_upd});
      push_exp("R10 pins after update", 64'h5);
      push_act({60'd0, pin_out});
      push_exp("R10 core_in follows pin_in", 64'h3);
      push_act({60'd0, core_in});

      core_out = 4'b1101;
      scan_ir(4'h3, cap);
      #1;
      push_exp("R11 core_in takes preloaded cells", 64'hA);
      push_act({60'd0, core_in});
      push_exp("R11 core-drive captures core_out", 64'hD3);
      scan_dr(8, 64'h7E, dout);
      push_act(dout);
      push_exp("R12 core_in holds until update edge", 64'hA);
      push_act({60'd0, core_at_upd});
      push_exp("R11 core_in after update", 64'hE);
      push_act({60'd0, core_in});
      push_exp("R11 pin_out follows core_out", 64'hD);
      push_act({60'd0, pin_out});

      step(1); step(0); step(0);
      for (int i = 0; i < 5; i++) step(1);
      step(0);
      #1;
      push_exp("R2 five highs restore transparency", 64'h3);
      push_act({60'd0, core_in});
      push_exp("R2 five highs reload id", {32'd0, IDV});
      scan_dr(32, 64'd0, dout);
      push_act(dout);

      scan_ir(4'h4, cap);
      @(negedge clk);
      #5;
      rst_n = 1'b0;
      #3;
      rst_n = 1'b1;
      step(0);
      push_exp("R1 async reset reloads id", {32'd0, IDV});
      scan_dr(32, 64'd0, dout);
      push_act(dout);

      wait (act_q.size() == 0);
      #1;
      if (exp_q.size() != 0) begin
         n_checks++;
         n_errors++;
         $display("FAIL scoreboard: actual %0d leftover expected 0", exp_q.size());
      end
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
   end

endmodule